// File: doc/BRIEF.md
# Debug Pin Override Multiplexer

This block sits between a small controller's general-purpose output logic and the pin pads of two 8-pin ports. In normal operation each pin's drive value and output enable come straight from the GPIO logic. Register settings can take over chosen pins and use them as debug outputs. A free-running 32 kHz clock can be routed to one pin of port 0. The on-chip digital regulator's power state can be routed to one pin of port 1. Four observation channels can each carry one of three internal observation signals onto the matching low pin of port 1.

Software reaches the settings through a byte-wide register bus. A write is a single-cycle strobe with no handshake, and reads are combinational. The block also takes the current power-mode code. In the two deepest modes the four observation settings are lost. In the deepest mode the routed clock stops, and its pin is held low.

Top module: `dbgmux_top`

## Requirements
- R1: While reset is asserted, and after it is released, every register reads 0 and all four pin outputs equal the matching GPIO inputs.
- R2: Register address 0 is the routing control register: bit 7 enables clock routing, bits 6:4 give the port-0 pin index, bit 3 enables status routing, and bits 2:0 give the port-1 pin index. Addresses 1 to 4 hold observation channels 0 to 3, each with bit 7 as enable and bits 6:0 as signal code. A write with `reg_we` high takes effect at the rising clock edge. Read data follows `reg_addr` combinationally. Addresses 5 to 7 read 0, and writes to them change nothing.
- R3: With clock routing enabled and `pmode` not equal to 3, port-0 pin k (k = bits 6:4) drives `slow_clk` with its output enable at 1, whatever its GPIO settings are.
- R4: With clock routing enabled and `pmode` equal to 3 (the deepest mode), the selected port-0 pin drives 0 with its output enable at 1.
- R5: With status routing enabled, port-1 pin k (k = bits 2:0) drives `vreg_up` (1 = regulator powered) with its output enable at 1, whatever its GPIO settings are.
- R6: When observation channel n is enabled and its code is 123, 124 or 125, port-1 pin n drives `obs_sig[0]`, `obs_sig[1]` or `obs_sig[2]` respectively, with its output enable at 1.
- R7: When observation channel n is enabled and its code is any other value, port-1 pin n drives 0 with its output enable at 1.
- R8: When status routing and an enabled observation channel select the same port-1 pin, that pin carries the regulator status.
- R9: At every rising edge with `pmode` equal to 2 or 3, all four observation registers clear to 0, and writes to them are ignored. The control register keeps its contents in every mode.
- R10: Every pin that no setting overrides drives exactly its GPIO output value and output enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| pmode | input | 2 | Power-mode code, 0 to 3, where 3 is the deepest |
| slow_clk | input | 1 | 32 kHz clock to route |
| vreg_up | input | 1 | Digital regulator powered flag |
| obs_sig | input | 3 | Internal observation signals |
| gpio0_out | input | 8 | Port-0 GPIO drive values |
| gpio0_oe | input | 8 | Port-0 GPIO output enables |
| gpio1_out | input | 8 | Port-1 GPIO drive values |
| gpio1_oe | input | 8 | Port-1 GPIO output enables |
| pin0_out | output | 8 | Final port-0 drive values |
| pin0_oe | output | 8 | Final port-0 output enables |
| pin1_out | output | 8 | Final port-1 drive values |
| pin1_oe | output | 8 | Final port-1 output enables |

## Verification
The bench uses the default parameters: four observation channels, three observation signals and a base code of 123. With so small a configuration it can visit every clock pin in every power mode, every status pin at both regulator states, and all 128 codes on each channel against all eight observation-signal patterns. Pin expectations are computed from a shadow copy of the registers that follows the write and power-mode rules. The sweep also covers every clash between status routing and an observation channel, and the loss of observation settings in the two deep modes.

// File: rtl/dbgmux_pkg.sv
package dbgmux_pkg;
  localparam int PORT_W    = 8;
  localparam int PIN_IDX_W = $clog2(PORT_W);
  localparam int REG_W     = 8;
  localparam int SEL_W     = REG_W - 1;

  typedef enum logic [1:0] {
    PWR_RUN   = 2'd0,
    PWR_LIGHT = 2'd1,
    PWR_LOSSY = 2'd2,
    PWR_DEEP  = 2'd3
  } pwr_mode_e;

  typedef struct packed {
    logic                 clk_en;
    logic [PIN_IDX_W-1:0] clk_pin;
    logic                 st_en;
    logic [PIN_IDX_W-1:0] st_pin;
  } route_ctrl_t;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] code;
  } obs_cfg_t;
endpackage

// File: rtl/dbgmux_regs.sv
module dbgmux_regs
  import dbgmux_pkg::*;
#(
  parameter int NUM_OBS = 4,
  parameter int ADDR_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  pwr_mode_e                pmode,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [REG_W-1:0]         wdata,
  output logic [REG_W-1:0]         rdata,
  output route_ctrl_t              ctrl_q,
  output obs_cfg_t [NUM_OBS-1:0]   obs_q
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;

  logic lossy;
  assign lossy = (pmode == PWR_LOSSY) || (pmode == PWR_DEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (we && addr == CTRL_ADDR) ctrl_q <= route_ctrl_t'(wdata);
  end

  // Observation settings are volatile in the two deepest modes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) obs_q <= '0;
    else if (lossy) obs_q <= '0;
    else begin
      for (int n = 0; n < NUM_OBS; n++) begin
        if (we && addr == ADDR_W'(n + 1)) obs_q[n] <= obs_cfg_t'(wdata);
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == CTRL_ADDR) rdata = ctrl_q;
    for (int n = 0; n < NUM_OBS; n++) begin
      if (addr == ADDR_W'(n + 1)) rdata = obs_q[n];
    end
  end

  AST_OBS_VOLATILE: assert property (@(posedge clk) disable iff (!rst_n)
    lossy |=> (obs_q == '0)); // R9
  AST_CTRL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == CTRL_ADDR) |=> $stable(ctrl_q)); // R9
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(addr) > NUM_OBS) |-> (rdata == '0)); // R2
endmodule

// File: rtl/dbgmux_obs_route.sv
module dbgmux_obs_route
  import dbgmux_pkg::*;
#(
  parameter int NUM_SIG   = 3,
  parameter int BASE_CODE = 123
) (
  input  obs_cfg_t           cfg,
  input  logic [NUM_SIG-1:0] obs_sig,
  output logic               drive,
  output logic               value
);
  assign drive = cfg.en;

  // Codes outside the defined window select a constant low
  always_comb begin
    value = 1'b0;
    for (int k = 0; k < NUM_SIG; k++) begin
      if (cfg.code == SEL_W'(BASE_CODE + k)) value = obs_sig[k];
    end
  end
endmodule

// File: rtl/dbgmux_top.sv
module dbgmux_top
  import dbgmux_pkg::*;
#(
  parameter int NUM_OBS   = 4,
  parameter int NUM_SIG   = 3,
  parameter int BASE_CODE = 123,
  parameter int ADDR_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [1:0]        pmode,
  input  logic              slow_clk,
  input  logic              vreg_up,
  input  logic [NUM_SIG-1:0] obs_sig,
  input  logic [PORT_W-1:0] gpio0_out,
  input  logic [PORT_W-1:0] gpio0_oe,
  input  logic [PORT_W-1:0] gpio1_out,
  input  logic [PORT_W-1:0] gpio1_oe,
  output logic [PORT_W-1:0] pin0_out,
  output logic [PORT_W-1:0] pin0_oe,
  output logic [PORT_W-1:0] pin1_out,
  output logic [PORT_W-1:0] pin1_oe
);
  pwr_mode_e             pm;
  route_ctrl_t           ctrl_q;
  obs_cfg_t [NUM_OBS-1:0] obs_q;
  logic [NUM_OBS-1:0]    obs_drive;
  logic [NUM_OBS-1:0]    obs_val;

  assign pm = pwr_mode_e'(pmode);

  dbgmux_regs #(.NUM_OBS(NUM_OBS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .pmode(pm), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ctrl_q(ctrl_q), .obs_q(obs_q)
  );

  for (genvar n = 0; n < NUM_OBS; n++) begin : g_obs
    dbgmux_obs_route #(.NUM_SIG(NUM_SIG), .BASE_CODE(BASE_CODE)) u_route (
      .cfg(obs_q[n]), .obs_sig(obs_sig),
      .drive(obs_drive[n]), .value(obs_val[n])
    );
  end

  // Port 0: clock routing over GPIO, held low in the deepest mode
  always_comb begin
    pin0_out = gpio0_out;
    pin0_oe  = gpio0_oe;
    if (ctrl_q.clk_en) begin
      pin0_out[ctrl_q.clk_pin] = (pm == PWR_DEEP) ? 1'b0 : slow_clk;
      pin0_oe[ctrl_q.clk_pin]  = 1'b1;
    end
  end

  // Port 1: GPIO < observation channel < regulator status
  always_comb begin
    pin1_out = gpio1_out;
    pin1_oe  = gpio1_oe;
    for (int n = 0; n < NUM_OBS; n++) begin
      if (obs_drive[n]) begin
        pin1_out[n] = obs_val[n];
        pin1_oe[n]  = 1'b1;
      end
    end
    if (ctrl_q.st_en) begin
      pin1_out[ctrl_q.st_pin] = vreg_up;
      pin1_oe[ctrl_q.st_pin]  = 1'b1;
    end
  end

  AST_CLK_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.clk_en && pm != PWR_DEEP) |->
      (pin0_out[ctrl_q.clk_pin] == slow_clk && pin0_oe[ctrl_q.clk_pin])); // R3
  AST_CLK_DEEP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.clk_en && pm == PWR_DEEP) |->
      (!pin0_out[ctrl_q.clk_pin] && pin0_oe[ctrl_q.clk_pin])); // R4
  AST_STATUS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.st_en |->
      (pin1_out[ctrl_q.st_pin] == vreg_up && pin1_oe[ctrl_q.st_pin])); // R8

  for (genvar n = 0; n < NUM_OBS; n++) begin : g_obs_chk
    AST_RESERVED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (obs_q[n].en && (int'(obs_q[n].code) < BASE_CODE ||
                       int'(obs_q[n].code) >= BASE_CODE + NUM_SIG) &&
       !(ctrl_q.st_en && int'(ctrl_q.st_pin) == n))
      |-> (!pin1_out[n] && pin1_oe[n])); // R7
  end

  for (genvar p = 0; p < PORT_W; p++) begin : g_pass_chk
    AST_P0_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_q.clk_en && int'(ctrl_q.clk_pin) == p) |->
        (pin0_out[p] == gpio0_out[p] && pin0_oe[p] == gpio0_oe[p])); // R10
  end
endmodule

// File: tb/dbgmux_top_tb.sv
module dbgmux_top_tb;
  logic clk = 1'b0;
  logic rst_n, reg_we, slow_clk, vreg_up;
  logic [2:0] reg_addr, obs_sig;
  logic [7:0] reg_wdata, reg_rdata;
  logic [1:0] pmode;
  logic [7:0] gpio0_out, gpio0_oe, gpio1_out, gpio1_oe;
  logic [7:0] pin0_out, pin0_oe, pin1_out, pin1_oe;

  int vecs = 0;
  int errs = 0;
  logic [7:0] sh_ctrl;
  logic [7:0] sh_obs [4];

  always #10 clk = ~clk;

  dbgmux_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pmode(pmode),
    .slow_clk(slow_clk), .vreg_up(vreg_up), .obs_sig(obs_sig),
    .gpio0_out(gpio0_out), .gpio0_oe(gpio0_oe),
    .gpio1_out(gpio1_out), .gpio1_oe(gpio1_oe),
    .pin0_out(pin0_out), .pin0_oe(pin0_oe),
    .pin1_out(pin1_out), .pin1_oe(pin1_oe)
  );

  task automatic rnd_gpio();
    gpio0_out = 8'($urandom); gpio0_oe = 8'($urandom);
    gpio1_out = 8'($urandom); gpio1_oe = 8'($urandom);
  endtask

  task automatic chk_pins(input string req);
    logic [7:0] e0o, e0e, e1o, e1e;
    #1;
    e0o = gpio0_out; e0e = gpio0_oe; e1o = gpio1_out; e1e = gpio1_oe;
    if (sh_ctrl[7]) begin
      e0o[sh_ctrl[6:4]] = (pmode == 2'd3) ? 1'b0 : slow_clk;
      e0e[sh_ctrl[6:4]] = 1'b1;
    end
    for (int n = 0; n < 4; n++) begin
      if (sh_obs[n][7]) begin
        int c;
        c = int'(sh_obs[n][6:0]);
        e1o[n] = (c >= 123 && c <= 125) ? obs_sig[c - 123] : 1'b0;
        e1e[n] = 1'b1;
      end
    end
    if (sh_ctrl[3]) begin
      e1o[sh_ctrl[2:0]] = vreg_up;
      e1e[sh_ctrl[2:0]] = 1'b1;
    end
    vecs++;
    if ({pin0_out, pin0_oe, pin1_out, pin1_oe} !== {e0o, e0e, e1o, e1e}) begin
      errs++;
      $display("FAIL %s pins: got %h %h %h %h expected %h %h %h %h", req,
               pin0_out, pin0_oe, pin1_out, pin1_oe, e0o, e0e, e1o, e1e);
    end
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    #1;
    vecs++;
    if (reg_rdata !== exp) begin
      errs++;
      $display("FAIL %s read addr %0d: got %h expected %h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 3'd0) sh_ctrl = d;
    else if (a <= 3'd4 && pmode < 2'd2) sh_obs[a - 3'd1] = d;
    if (pmode >= 2'd2) for (int n = 0; n < 4; n++) sh_obs[n] = '0;
  endtask

  task automatic set_pm(input logic [1:0] p);
    @(negedge clk);
    pmode = p;
    @(negedge clk);
    if (p >= 2'd2) for (int n = 0; n < 4; n++) sh_obs[n] = '0;
  endtask

  initial begin
    #2_000_000;
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; pmode = 2'd0;
    slow_clk = 1'b0; vreg_up = 1'b0; obs_sig = '0;
    sh_ctrl = '0; for (int n = 0; n < 4; n++) sh_obs[n] = '0;
    rnd_gpio();
    repeat (3) @(negedge clk);
    chk_pins("R1");
    for (int a = 0; a < 8; a++) chk_rd(3'(a), 8'h00, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    rnd_gpio();
    chk_pins("R1");

    // R2: register map readback, unmapped addresses
    for (int a = 0; a < 8; a++) wr(3'(a), 8'(8'h35 + a * 29) & 8'h77);
    for (int a = 0; a < 8; a++)
      chk_rd(3'(a), (a <= 4) ? (8'(8'h35 + a * 29) & 8'h77) : 8'h00, "R2");
    chk_pins("R2");
    for (int a = 0; a < 5; a++) wr(3'(a), 8'h00);

    // R3 / R4: clock routing across pins and power modes
    for (int p = 0; p < 4; p++) begin
      set_pm(2'(p));
      for (int en = 0; en < 2; en++)
        for (int k = 0; k < 8; k++) begin
          wr(3'd0, {1'(en), 3'(k), 4'b0000});
          for (int s = 0; s < 2; s++) begin
            slow_clk = 1'(s); rnd_gpio();
            chk_pins((p == 3) ? "R4" : "R3");
          end
        end
    end
    set_pm(2'd0);

    // R5: status routing
    for (int en = 0; en < 2; en++)
      for (int k = 0; k < 8; k++) begin
        wr(3'd0, {4'b0000, 1'(en), 3'(k)});
        for (int v = 0; v < 2; v++) begin
          vreg_up = 1'(v); rnd_gpio();
          chk_pins("R5");
        end
      end
    wr(3'd0, 8'h00);

    // R6 / R7: every code on every channel
    for (int ch = 0; ch < 4; ch++) begin
      for (int c = 0; c < 128; c++) begin
        wr(3'(ch + 1), {1'b1, 7'(c)});
        for (int s = 0; s < 8; s++) begin
          obs_sig = 3'(s);
          chk_pins((c >= 123 && c <= 125) ? "R6" : "R7");
        end
      end
      wr(3'(ch + 1), {1'b0, 7'd124});
      chk_pins("R10");
    end

    // R8: status against observation on the same pin
    for (int n = 0; n < 4; n++) wr(3'(n + 1), {1'b1, 7'(123 + n % 3)});
    for (int k = 0; k < 8; k++) begin
      wr(3'd0, {4'b0000, 1'b1, 3'(k)});
      for (int v = 0; v < 2; v++)
        for (int s = 0; s < 8; s++) begin
          vreg_up = 1'(v); obs_sig = 3'(s); rnd_gpio();
          chk_pins("R8");
        end
    end

    // R9: volatile observation settings, retained control
    wr(3'd0, 8'hB5);
    for (int n = 0; n < 4; n++) wr(3'(n + 1), 8'hFC);
    obs_sig = 3'b111;
    chk_pins("R9");
    for (int p = 2; p < 4; p++) begin
      set_pm(2'(p));
      for (int n = 0; n < 4; n++) chk_rd(3'(n + 1), 8'h00, "R9");
      chk_rd(3'd0, 8'hB5, "R9");
      chk_pins("R9");
      wr(3'd2, 8'hFD);
      chk_rd(3'd2, 8'h00, "R9");
      chk_pins("R9");
      set_pm(2'd1);
      chk_rd(3'd1, 8'h00, "R9");
      wr(3'd1, 8'hFB);
      chk_rd(3'd1, 8'hFB, "R9");
      chk_pins("R9");
    end
    set_pm(2'd0);

    // R10: no overrides, random GPIO
    for (int a = 0; a < 5; a++) wr(3'(a), 8'h00);
    for (int i = 0; i < 200; i++) begin
      rnd_gpio(); slow_clk = 1'(i); vreg_up = 1'(i >> 1); obs_sig = 3'(i);
      chk_pins("R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule